// File: doc/BRIEF.md
# Ring Relay Sequencer with Line Supervision

This block is the digital controller of an analog telephone line interface. It decides when the external ring relay is energised. It also turns two digitised loop measurements into hook and ground-key status. The system controller requests ringing with an active-low command. A zero-crossing clock from the ring generator lets the block switch the relay contacts only when the ring voltage is near zero. A power-denial input shuts the line down when the exchange is overloaded.

The loop-current code and the tip/ring imbalance code are unsigned milliamp values. They are sampled on the system clock and compared against two-level thresholds, so a noisy reading near one level cannot make the status flicker. The command, denial and zero-crossing pins are asynchronous and are brought in through two-flop synchronisers.

The block watches the zero-crossing clock. If no rising edge arrives for a set number of system clocks, it stops waiting for edges and lets the ring command act directly. When the subscriber lifts the handset during ringing (ring trip), the relay is dropped at once. All outputs are plain registered levels and there is no stream interface. All outputs are high (inactive) in reset.

Top module: `ring_relay_ctrl`

## Requirements
- R1: `hook_n` goes low once `loop_ma` exceeds HOOK_SET (10). It returns high only once `loop_ma` is below HOOK_CLR (5). For codes from 5 to 10 inclusive it keeps its previous level.
- R2: `gkey_n` goes low once `imbal_ma` exceeds GK_SET (20). It returns high only once `imbal_ma` is below GK_CLR (10). In between it keeps its level.
- R3: In synchronised mode, `relay_n` goes low only after a rising edge of `ring_sync` seen while `ring_cmd_n` is low. A command that goes low between edges has no effect until the next rising edge.
- R4: In synchronised mode, raising `ring_cmd_n` releases the relay (`relay_n` high) only at the next rising edge of `ring_sync`.
- R5: While the line is off-hook (R1 state active), `relay_n` is high, within 2 clocks of the hook state setting. Once the line is back on-hook with the command still low, the relay re-engages at a later rising edge of `ring_sync`.
- R6: While `deny_n` is low, `relay_n`, `hook_n` and `gkey_n` are all high, within 3 clocks of the pin falling. The relay stays released across ring-sync edges.
- R7: If no rising edge of `ring_sync` has been seen for SYNC_TIMEOUT clocks, `relay_n` follows the inverse of the synchronised `ring_cmd_n` within 4 clocks, without waiting for an edge.
- R8: After synchronous reset, `relay_n`, `hook_n` and `gkey_n` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_cmd_n | input | 1 | Ring request, active low, asynchronous |
| deny_n | input | 1 | Power denial, active low, asynchronous |
| ring_sync | input | 1 | Zero-crossing clock from the ring source, rising edge marks a crossing |
| loop_ma | input | W | Loop current code in mA, synchronous to clk |
| imbal_ma | input | W | Ring-minus-tip current difference in mA, synchronous to clk |
| relay_n | output | 1 | Ring relay drive, active low |
| hook_n | output | 1 | Off-hook detect, active low |
| gkey_n | output | 1 | Ground-key detect, active low |

## Verification
The bench builds the block with W=8, the default thresholds 10/5 and 20/10, and SYNC_TIMEOUT=64. With a ring-sync period of 40 clocks, the block stays synchronised while the bench toggles the zero-crossing clock. Holding `ring_sync` high for 80 clocks lets the bench enter and test free-running mode within a short run. Random codes from 0 to 20 and from 0 to 40 cover both sides of each threshold and the hold band between them. Directed steps place command changes between sync edges, and apply ring trip and denial while the relay is engaged.

// File: rtl/ring_relay_pkg.sv
`timescale 1ns/1ps
package ring_relay_pkg;
  // Asynchronous control pins gathered for one synchroniser bank
  typedef struct packed {
    logic cmd_n;
    logic deny_n;
    logic zc;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '{cmd_n: 1'b1, deny_n: 1'b1, zc: 1'b0};
endpackage

// File: rtl/rr_sync2.sv
`timescale 1ns/1ps
module rr_sync2 #(
  parameter int           N    = 1,
  parameter logic [N-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic meta, hold;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta <= INIT[i];
        hold <= INIT[i];
      end else begin
        meta <= d[i];
        hold <= meta;
      end
    end
    assign q[i] = hold;
  end
endmodule

// File: rtl/rr_hyst_det.sv
`timescale 1ns/1ps
module rr_hyst_det #(
  parameter int W         = 8,
  parameter int SET_ABOVE = 10,
  parameter int CLR_BELOW = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] level,
  output logic         active
);
  localparam logic [W-1:0] SET_L = SET_ABOVE[W-1:0];
  localparam logic [W-1:0] CLR_L = CLR_BELOW[W-1:0];

  always_ff @(posedge clk) begin
    if (rst)                active <= 1'b0;
    else if (level > SET_L) active <= 1'b1;
    else if (level < CLR_L) active <= 1'b0;
  end
endmodule

// File: rtl/rr_sync_watch.sv
`timescale 1ns/1ps
module rr_sync_watch #(
  parameter int TIMEOUT = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic zc,
  output logic zc_edge,
  output logic free_run
);
  localparam int            CW  = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LIM = TIMEOUT[CW-1:0];

  logic          zc_d;
  logic [CW-1:0] gap;

  assign zc_edge  = zc & ~zc_d;
  assign free_run = (gap == LIM);

  always_ff @(posedge clk) begin
    if (rst) begin
      zc_d <= 1'b0;
      gap  <= LIM;
    end else begin
      zc_d <= zc;
      if (zc_edge)         gap <= '0;
      else if (gap != LIM) gap <= gap + 1'b1;
    end
  end
endmodule

// File: rtl/ring_relay_ctrl.sv
`timescale 1ns/1ps
module ring_relay_ctrl #(
  parameter int W            = 8,
  parameter int HOOK_SET     = 10,
  parameter int HOOK_CLR     = 5,
  parameter int GK_SET       = 20,
  parameter int GK_CLR       = 10,
  parameter int SYNC_TIMEOUT = 1024
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ring_cmd_n,
  input  logic         deny_n,
  input  logic         ring_sync,
  input  logic [W-1:0] loop_ma,
  input  logic [W-1:0] imbal_ma,
  output logic         relay_n,
  output logic         hook_n,
  output logic         gkey_n
);
  import ring_relay_pkg::*;

  localparam int CTL_W = $bits(ctl_t);

  ctl_t raw, ctl;
  logic zc_edge, free_run;
  logic hook_active, gk_active;
  logic relay_on;

  assign raw = '{cmd_n: ring_cmd_n, deny_n: deny_n, zc: ring_sync};

  rr_sync2 #(.N(CTL_W), .INIT(CTL_IDLE)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw),
    .q   (ctl)
  );

  rr_sync_watch #(.TIMEOUT(SYNC_TIMEOUT)) u_watch (
    .clk      (clk),
    .rst      (rst),
    .zc       (ctl.zc),
    .zc_edge  (zc_edge),
    .free_run (free_run)
  );

  rr_hyst_det #(.W(W), .SET_ABOVE(HOOK_SET), .CLR_BELOW(HOOK_CLR)) u_hook (
    .clk    (clk),
    .rst    (rst),
    .level  (loop_ma),
    .active (hook_active)
  );

  rr_hyst_det #(.W(W), .SET_ABOVE(GK_SET), .CLR_BELOW(GK_CLR)) u_gkey (
    .clk    (clk),
    .rst    (rst),
    .level  (imbal_ma),
    .active (gk_active)
  );

  // Relay state: vetoes first, then command taken at a zero crossing or at once when free-running
  always_ff @(posedge clk) begin
    if (rst)                              relay_on <= 1'b0;
    else if (!ctl.deny_n || hook_active)  relay_on <= 1'b0;
    else if (zc_edge || free_run)         relay_on <= !ctl.cmd_n;
  end

  // Registered output stage
  always_ff @(posedge clk) begin
    if (rst) begin
      relay_n <= 1'b1;
      hook_n  <= 1'b1;
      gkey_n  <= 1'b1;
    end else begin
      relay_n <= !(relay_on && ctl.deny_n && !hook_active);
      hook_n  <= !(hook_active && ctl.deny_n);
      gkey_n  <= !(gk_active && ctl.deny_n);
    end
  end
endmodule

// File: rtl/ring_relay_ctrl_chk.sv
`timescale 1ns/1ps
module ring_relay_ctrl_chk #(
  parameter int W        = 8,
  parameter int HOOK_SET = 10,
  parameter int HOOK_CLR = 5,
  parameter int GK_SET   = 20,
  parameter int GK_CLR   = 10
) (
  input logic         clk,
  input logic         rst,
  input logic         deny_s,
  input logic         cmd_s,
  input logic         zc_edge,
  input logic         free_run,
  input logic         hook_active,
  input logic         gk_active,
  input logic         relay_on,
  input logic [W-1:0] loop_ma,
  input logic [W-1:0] imbal_ma,
  input logic         relay_n,
  input logic         hook_n,
  input logic         gkey_n
);
  localparam logic [W-1:0] HS = HOOK_SET[W-1:0];
  localparam logic [W-1:0] HC = HOOK_CLR[W-1:0];
  localparam logic [W-1:0] GS = GK_SET[W-1:0];
  localparam logic [W-1:0] GC = GK_CLR[W-1:0];

  // R1
  hook_set_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hook_active) |-> ($past(loop_ma) > HS));
  // R1
  hook_clr_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(hook_active) |-> ($past(loop_ma) < HC));
  // R2
  gkey_set_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(gk_active) |-> ($past(imbal_ma) > GS));
  // R2
  gkey_clr_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(gk_active) |-> ($past(imbal_ma) < GC));
  // R3
  relay_engage_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(relay_on) |-> ($past(zc_edge || free_run) && !$past(cmd_s)));
  // R4
  relay_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(relay_on) |-> $past(!deny_s || hook_active || ((zc_edge || free_run) && cmd_s)));
  // R5
  trip_release_chk: assert property (@(posedge clk) disable iff (rst)
    hook_active |=> (relay_n && !relay_on));
  // R6
  deny_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !deny_s |=> (relay_n && hook_n && gkey_n));
endmodule

bind ring_relay_ctrl ring_relay_ctrl_chk #(
  .W(W), .HOOK_SET(HOOK_SET), .HOOK_CLR(HOOK_CLR), .GK_SET(GK_SET), .GK_CLR(GK_CLR)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .deny_s      (ctl.deny_n),
  .cmd_s       (ctl.cmd_n),
  .zc_edge     (zc_edge),
  .free_run    (free_run),
  .hook_active (hook_active),
  .gk_active   (gk_active),
  .relay_on    (relay_on),
  .loop_ma     (loop_ma),
  .imbal_ma    (imbal_ma),
  .relay_n     (relay_n),
  .hook_n      (hook_n),
  .gkey_n      (gkey_n)
);

// File: tb/test_ring_relay_ctrl.sv
`timescale 1ns/1ps
module test_ring_relay_ctrl;
  localparam int W   = 8;
  localparam int TMO = 64;
  localparam int HALF_SYNC = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ring_cmd_n = 1'b1;
  logic deny_n = 1'b1;
  logic ring_sync = 1'b1;
  logic [W-1:0] loop_ma = '0;
  logic [W-1:0] imbal_ma = '0;
  logic relay_n, hook_n, gkey_n;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit tog_en = 1'b0;
  int ph = 0;
  logic hook_st = 1'b0;
  logic gk_st = 1'b0;

  always #2.5 clk = ~clk;

  ring_relay_ctrl #(.W(W), .SYNC_TIMEOUT(TMO)) i_ring_relay_ctrl (
    .clk(clk), .rst(rst), .ring_cmd_n(ring_cmd_n), .deny_n(deny_n),
    .ring_sync(ring_sync), .loop_ma(loop_ma), .imbal_ma(imbal_ma),
    .relay_n(relay_n), .hook_n(hook_n), .gkey_n(gkey_n)
  );

  // Zero-crossing source: toggles every HALF_SYNC clocks when enabled, held high otherwise
  initial begin
    forever begin
      @(negedge clk);
      if (tog_en) begin
        ph++;
        if (ph == HALF_SYNC) begin
          ring_sync = ~ring_sync;
          ph = 0;
        end
      end else begin
        ring_sync = 1'b1;
        ph = 0;
      end
    end
  end

  function automatic logic hyst(logic prev, int v, int set_above, int clr_below);
    if (v > set_above) return 1'b1;
    if (v < clr_below) return 1'b0;
    return prev;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%b exp=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_levels(int l, int g);
    loop_ma  = l[W-1:0];
    imbal_ma = g[W-1:0];
    hook_st  = hyst(hook_st, l, 10, 5);
    gk_st    = hyst(gk_st, g, 20, 10);
  endtask

  task automatic next_zc(int settle);
    @(posedge ring_sync);
    wclk(settle);
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4021));
    wclk(4);
    rst = 1'b0;
    wclk(2);
    // R8 reset state
    chk("R8 relay", relay_n, 1'b1);
    chk("R8 hook", hook_n, 1'b1);
    chk("R8 gkey", gkey_n, 1'b1);

    // R1 / R2 directed corners around the thresholds
    set_levels(10, 20); wclk(4);
    chk("R1 at 10 holds off", hook_n, ~hook_st);
    chk("R2 at 20 holds off", gkey_n, ~gk_st);
    set_levels(11, 21); wclk(4);
    chk("R1 above set", hook_n, 1'b0);
    chk("R2 above set", gkey_n, 1'b0);
    set_levels(5, 10); wclk(4);
    chk("R1 at 5 holds on", hook_n, 1'b0);
    chk("R2 at 10 holds on", gkey_n, 1'b0);
    set_levels(4, 9); wclk(4);
    chk("R1 below clear", hook_n, 1'b1);
    chk("R2 below clear", gkey_n, 1'b1);

    // R1 / R2 random codes across both thresholds
    for (int i = 0; i < 40; i++) begin
      set_levels(int'($urandom_range(0, 20)), int'($urandom_range(0, 40)));
      wclk(4);
      chk("R1 random", hook_n, ~hook_st);
      chk("R2 random", gkey_n, ~gk_st);
    end
    set_levels(0, 0); wclk(4);

    // R7 free-running (sync held high since reset)
    wclk(TMO + 16);
    ring_cmd_n = 1'b0; wclk(6);
    chk("R7 engage free-run", relay_n, 1'b0);
    ring_cmd_n = 1'b1; wclk(6);
    chk("R7 release free-run", relay_n, 1'b1);

    // R3 / R4 synchronised switching
    tog_en = 1'b1;
    next_zc(3);
    ring_cmd_n = 1'b0; wclk(10);
    chk("R3 waits for edge", relay_n, 1'b1);
    next_zc(6);
    chk("R3 engage at edge", relay_n, 1'b0);
    wclk(3);
    ring_cmd_n = 1'b1; wclk(10);
    chk("R4 waits for edge", relay_n, 1'b0);
    next_zc(6);
    chk("R4 release at edge", relay_n, 1'b1);

    // R5 ring trip
    ring_cmd_n = 1'b0;
    next_zc(6);
    chk("R5 pre-trip engaged", relay_n, 1'b0);
    set_levels(15, 0); wclk(4);
    chk("R5 trip release", relay_n, 1'b1);
    chk("R1 trip hook", hook_n, 1'b0);
    next_zc(6);
    chk("R5 stays released", relay_n, 1'b1);
    set_levels(0, 0);
    next_zc(6);
    chk("R5 re-engage on-hook", relay_n, 1'b0);
    chk("R1 on-hook", hook_n, 1'b1);

    // R6 power denial
    deny_n = 1'b0;
    set_levels(15, 30); wclk(5);
    chk("R6 relay", relay_n, 1'b1);
    chk("R6 hook", hook_n, 1'b1);
    chk("R6 gkey", gkey_n, 1'b1);
    next_zc(6);
    chk("R6 relay across edge", relay_n, 1'b1);
    deny_n = 1'b1; wclk(5);
    chk("R1 after denial", hook_n, ~hook_st);
    chk("R2 after denial", gkey_n, ~gk_st);
    chk("R5 hook veto after denial", relay_n, 1'b1);
    set_levels(0, 0);
    next_zc(6);
    chk("R3 engage after denial", relay_n, 1'b0);
    chk("R2 cleared", gkey_n, 1'b1);

    // R7 return to free-running
    tog_en = 1'b0;
    wclk(TMO + 16);
    chk("R7 holds engaged", relay_n, 1'b0);
    ring_cmd_n = 1'b1; wclk(6);
    chk("R7 release at once", relay_n, 1'b1);
    ring_cmd_n = 1'b0; wclk(6);
    chk("R7 engage at once", relay_n, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule